// File: doc/BRIEF.md
# Security Error Status Register

This block keeps an 8-bit record of security faults for a platform protection controller. Hardware event inputs set individual flags. Firmware can also force three of them on through a set register. Flags are cleared by writing ones through a private access window. A public window can read the same contents, but its writes do nothing.

The flags hold across a warm system reset and are zeroed only by the power-on reset. One flag records whether memory may still contain secrets. During a warm reset, a handshake acknowledge sets or clears it. Whenever that flag is set at reset, a memory-lock output is armed. The lock stays on until firmware issues an explicit memory-enable write. A poison flag drives a poison output that only power-on can remove.

The access port is a single-cycle register port. Address 0 is the status register, address 1 is the set register and address 2 is the memory-enable strobe. Address 3 is unused.

Top module: `sec_err_status`

## Requirements
- R1: A public-window access (`reg_priv_i`=0) at address 0 reads the status. A public write to any address changes no flag and does not touch `mem_lock_o`.
- R2: A private write to address 0 clears every status bit from 1 to 6 whose write-data position holds a 1. Positions holding a 0 keep their value.
- R3: A warm reset (`warm_rst_i`=1) leaves the flags unchanged. Power-on reset (`por_ni`=0) zeroes all flags, `mem_lock_o`, `poison_o` and the read data.
- R4: Bit 6 is the wake-error flag. While `warm_rst_i` is high, `ack_secrets_i` sets it and `ack_clean_i` clears it. If both arrive together, the set wins. Outside warm reset, both acknowledges are ignored.
- R5: While `warm_rst_i` is high, `mem_lock_o` takes the next value of bit 6. Outside warm reset, a private write to address 2 releases the lock. A public write to address 2 does not release it.
- R6: `alias_fault_i` sets bit 5, `rogue_exit_i` sets bit 1 and `dram_illegal_i` sets bit 2.
- R7: A private write to address 1 sets bits 4, 3 and 2 wherever the write data holds a 1. All other data bits are ignored.
- R8: `poison_cycle_i` sets bit 0. Bit 0 is immune to write-one-to-clear and to warm reset. `poison_o` follows bit 0.
- R9: Bit 7 always reads 0.
- R10: When a hardware set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: Read data appears on the cycle after the request. Reads of addresses 1 to 3, and cycles without a read, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm system reset window, active high |
| ack_secrets_i | input | 1 | Reset handshake: memory may hold secrets |
| ack_clean_i | input | 1 | Reset handshake: memory holds no secrets |
| alias_fault_i | input | 1 | Address alias fault event |
| rogue_exit_i | input | 1 | Improper secure-environment exit event |
| dram_illegal_i | input | 1 | Illegal DRAM read event |
| poison_cycle_i | input | 1 | Poison cycle received |
| reg_req_i | input | 1 | Access request |
| reg_priv_i | input | 1 | 1 = private window, 0 = public window |
| reg_we_i | input | 1 | Write enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one cycle after the request |
| mem_lock_o | output | 1 | Memory accesses blocked |
| poison_o | output | 1 | Platform poisoned |

## Verification
Two functions can fall in the same cycle: a hardware event setting a flag, and a private write-one-to-clear aimed at that same flag. The bench raises the alias-fault or illegal-read input in exactly the cycle that carries the clearing write. It then reads the status back and expects the flag to be set. The wake-error flag has a second collision: both reset acknowledges arriving in one warm-reset cycle, which must leave the flag and the lock set.

// File: rtl/sec_err_pkg.sv
package sec_err_pkg;
  localparam int unsigned STS_W = 8;

  localparam int unsigned B_POISON = 0;
  localparam int unsigned B_ROGUE  = 1;
  localparam int unsigned B_MEMATK = 2;
  localparam int unsigned B_ALIAS  = 5;
  localparam int unsigned B_WAKE   = 6;

  localparam logic [STS_W-1:0] IMPL_MASK   = 8'h7F;
  localparam logic [STS_W-1:0] CLEARABLE   = 8'h7E;
  localparam logic [STS_W-1:0] SETREG_MASK = 8'h1C;

  localparam int unsigned ADR_STATUS = 0;
  localparam int unsigned ADR_SETREG = 1;
  localparam int unsigned ADR_MEMEN  = 2;

  // set dominates clear; unimplemented bits forced to 0
  function automatic logic [STS_W-1:0] flag_next(
    input logic [STS_W-1:0] cur,
    input logic [STS_W-1:0] set,
    input logic [STS_W-1:0] clr
  );
    return ((cur & ~clr) | set) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/sec_err_access.sv
module sec_err_access
  import sec_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              req_i,
  input  logic              priv_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STS_W-1:0]  wdata_i,
  input  logic [STS_W-1:0]  flags_i,
  output logic [STS_W-1:0]  clr_mask_o,
  output logic [STS_W-1:0]  set_mask_o,
  output logic              mem_en_o,
  output logic [STS_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADR_SETREG);
  localparam logic [ADDR_W-1:0] A_MEN = ADDR_W'(ADR_MEMEN);

  logic priv_wr;
  logic sts_rd;

  assign priv_wr = req_i & we_i & priv_i;
  assign sts_rd  = req_i & ~we_i & (addr_i == A_STS);

  assign clr_mask_o = (priv_wr && addr_i == A_STS) ? (wdata_i & CLEARABLE)   : '0;
  assign set_mask_o = (priv_wr && addr_i == A_SET) ? (wdata_i & SETREG_MASK) : '0;
  assign mem_en_o   = priv_wr && (addr_i == A_MEN);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) rdata_o <= '0;
    else         rdata_o <= sts_rd ? flags_i : '0;
  end
endmodule

// File: rtl/sec_err_flags.sv
module sec_err_flags
  import sec_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             warm_rst_i,
  input  logic             ack_secrets_i,
  input  logic             ack_clean_i,
  input  logic             alias_fault_i,
  input  logic             rogue_exit_i,
  input  logic             dram_illegal_i,
  input  logic             poison_cycle_i,
  input  logic [STS_W-1:0] clr_mask_i,
  input  logic [STS_W-1:0] set_mask_i,
  output logic [STS_W-1:0] hw_set_o,
  output logic [STS_W-1:0] hw_clr_o,
  output logic [STS_W-1:0] flags_d_o,
  output logic [STS_W-1:0] flags_q_o
);
  always_comb begin
    hw_set_o           = set_mask_i;
    hw_set_o[B_ALIAS]  = hw_set_o[B_ALIAS]  | alias_fault_i;
    hw_set_o[B_ROGUE]  = hw_set_o[B_ROGUE]  | rogue_exit_i;
    hw_set_o[B_MEMATK] = hw_set_o[B_MEMATK] | dram_illegal_i;
    hw_set_o[B_POISON] = hw_set_o[B_POISON] | poison_cycle_i;
    hw_set_o[B_WAKE]   = hw_set_o[B_WAKE]   | (warm_rst_i & ack_secrets_i);
  end

  always_comb begin
    hw_clr_o         = clr_mask_i;
    hw_clr_o[B_WAKE] = hw_clr_o[B_WAKE] | (warm_rst_i & ack_clean_i);
  end

  assign flags_d_o = flag_next(flags_q_o, hw_set_o, hw_clr_o);

  // only power-on reset clears; warm reset has no path here
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) flags_q_o <= '0;
    else         flags_q_o <= flags_d_o;
  end
endmodule

// File: rtl/sec_err_lock.sv
module sec_err_lock (
  input  logic clk_i,
  input  logic por_ni,
  input  logic warm_rst_i,
  input  logic wake_next_i,
  input  logic mem_en_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         lock_o <= 1'b0;
    else if (warm_rst_i) lock_o <= wake_next_i;
    else if (mem_en_i)   lock_o <= 1'b0;
  end
endmodule

// File: rtl/sec_err_status.sv
module sec_err_status
  import sec_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              warm_rst_i,
  input  logic              ack_secrets_i,
  input  logic              ack_clean_i,
  input  logic              alias_fault_i,
  input  logic              rogue_exit_i,
  input  logic              dram_illegal_i,
  input  logic              poison_cycle_i,
  input  logic              reg_req_i,
  input  logic              reg_priv_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_lock_o,
  output logic              poison_o
);
  // named internal events, observed by the bound checker
  logic [STS_W-1:0] clr_mask;
  logic [STS_W-1:0] set_mask;
  logic [STS_W-1:0] hw_set;
  logic [STS_W-1:0] hw_clr;
  logic [STS_W-1:0] flags_d;
  logic [STS_W-1:0] flags_q;
  logic             mem_en;

  sec_err_access #(.ADDR_W(ADDR_W)) u_access (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .req_i      (reg_req_i),
    .priv_i     (reg_priv_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flags_i    (flags_q),
    .clr_mask_o (clr_mask),
    .set_mask_o (set_mask),
    .mem_en_o   (mem_en),
    .rdata_o    (reg_rdata_o)
  );

  sec_err_flags u_flags (
    .clk_i          (clk_i),
    .por_ni         (por_ni),
    .warm_rst_i     (warm_rst_i),
    .ack_secrets_i  (ack_secrets_i),
    .ack_clean_i    (ack_clean_i),
    .alias_fault_i  (alias_fault_i),
    .rogue_exit_i   (rogue_exit_i),
    .dram_illegal_i (dram_illegal_i),
    .poison_cycle_i (poison_cycle_i),
    .clr_mask_i     (clr_mask),
    .set_mask_i     (set_mask),
    .hw_set_o       (hw_set),
    .hw_clr_o       (hw_clr),
    .flags_d_o      (flags_d),
    .flags_q_o      (flags_q)
  );

  sec_err_lock u_lock (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .warm_rst_i  (warm_rst_i),
    .wake_next_i (flags_d[B_WAKE]),
    .mem_en_i    (mem_en),
    .lock_o      (mem_lock_o)
  );

  assign poison_o = flags_q[B_POISON];
endmodule

// File: rtl/sec_err_status_chk.sv
module sec_err_status_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              por_ni,
  input logic              warm_rst_i,
  input logic              reg_req_i,
  input logic              reg_priv_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_rdata_o,
  input logic              mem_lock_o,
  input logic              poison_o,
  input logic [7:0]        flags_q,
  input logic [7:0]        hw_set,
  input logic              mem_en
);
  // R1: public writes never drop a flag
  a_r1_public_write_inert: assert property (@(posedge clk_i) disable iff (!por_ni)
    (reg_req_i && reg_we_i && !reg_priv_i && !warm_rst_i)
      |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5: enable strobe outside warm reset releases the lock
  a_r5_lock_release: assert property (@(posedge clk_i) disable iff (!por_ni)
    (mem_en && !warm_rst_i) |=> !mem_lock_o);

  // R8: poison stays until power-on
  a_r8_poison_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    poison_o |=> poison_o);

  // R9: reserved bit reads zero
  a_r9_bit7_zero: assert property (@(posedge clk_i) disable iff (!por_ni)
    reg_rdata_o[7] == 1'b0);

  // R10: every hardware set lands even against a clear
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!por_ni)
    (|hw_set) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

  // R11: non-status reads return zero next cycle
  a_r11_other_reads_zero: assert property (@(posedge clk_i) disable iff (!por_ni)
    (reg_req_i && !reg_we_i && reg_addr_i != '0) |=> (reg_rdata_o == 8'h00));
endmodule

bind sec_err_status sec_err_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .por_ni      (por_ni),
  .warm_rst_i  (warm_rst_i),
  .reg_req_i   (reg_req_i),
  .reg_priv_i  (reg_priv_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_lock_o  (mem_lock_o),
  .poison_o    (poison_o),
  .flags_q     (flags_q),
  .hw_set      (hw_set),
  .mem_en      (mem_en)
);

// File: tb/sim_sec_err_status.sv
module sim_sec_err_status;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm = 1'b0, ack_s = 1'b0, ack_c = 1'b0;
  logic       ev_alias = 1'b0, ev_rogue = 1'b0, ev_dram = 1'b0, ev_poison = 1'b0;
  logic       req = 1'b0, priv = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       lock, poison;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [7:0] m_flags = 8'h00;
  logic [7:0] m_rd = 8'h00;
  logic       m_lock = 1'b0;
  logic [7:0] s, c, nf;
  logic       pw;

  always #2 clk = ~clk;

  sec_err_status #(.ADDR_W(2)) u0 (
    .clk_i(clk), .por_ni(por_n), .warm_rst_i(warm),
    .ack_secrets_i(ack_s), .ack_clean_i(ack_c),
    .alias_fault_i(ev_alias), .rogue_exit_i(ev_rogue),
    .dram_illegal_i(ev_dram), .poison_cycle_i(ev_poison),
    .reg_req_i(req), .reg_priv_i(priv), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .mem_lock_o(lock), .poison_o(poison)
  );

  // one clock; the model follows the requirements from the inputs held since the last negedge
  task automatic step();
    @(posedge clk);
    if (!por_n) begin
      m_flags = 8'h00; m_lock = 1'b0; m_rd = 8'h00;
    end else begin
      pw = req & we & priv;
      s = 8'h00;
      s[5] = ev_alias; s[1] = ev_rogue; s[2] = ev_dram; s[0] = ev_poison;
      if (warm && ack_s) s[6] = 1'b1;
      if (pw && addr == 2'd1) s = s | (wd & 8'h1C);
      c = 8'h00;
      if (pw && addr == 2'd0) c = wd & 8'h7E;
      if (warm && ack_c) c[6] = 1'b1;
      m_rd = (req && !we && addr == 2'd0) ? m_flags : 8'h00;
      nf = ((m_flags & ~c) | s) & 8'h7F;
      if (warm) m_lock = nf[6];
      else if (pw && addr == 2'd2) m_lock = 1'b0;
      m_flags = nf;
    end
    @(negedge clk);
  endtask

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(logic p, logic w, logic [1:0] a, logic [7:0] d);
    req = 1'b1; priv = p; we = w; addr = a; wd = d;
    step();
    req = 1'b0; priv = 1'b0; we = 1'b0; addr = 2'd0; wd = 8'h00;
  endtask

  task automatic rd_chk(string r, logic [7:0] exp);
    acc(1'b0, 1'b0, 2'd0, 8'h00);
    chk(r, rdata, m_rd);
    chk(r, rdata, exp);
  endtask

  task automatic ev(logic a, logic r, logic d, logic p);
    ev_alias = a; ev_rogue = r; ev_dram = d; ev_poison = p;
    step();
    ev_alias = 1'b0; ev_rogue = 1'b0; ev_dram = 1'b0; ev_poison = 1'b0;
  endtask

  task automatic warm_rst(logic sec, logic cln);
    warm = 1'b1; ack_s = sec; ack_c = cln;
    step();
    ack_s = 1'b0; ack_c = 1'b0;
    step();
    warm = 1'b0;
    step();
  endtask

  task automatic por_pulse();
    por_n = 1'b0;
    step();
    por_n = 1'b1;
    step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    step(); step();
    por_n = 1'b1;
    step();

    // R3: power-on state
    chk("R3 reset rdata", rdata, 8'h00);
    chk("R3 reset lock/poison", {6'd0, lock, poison}, 8'h00);
    rd_chk("R3 reset status", 8'h00);

    // R6: individual event inputs
    ev(1'b1, 1'b0, 1'b0, 1'b0); rd_chk("R6 alias bit5", 8'h20);
    acc(1'b1, 1'b1, 2'd0, 8'hFF);
    ev(1'b0, 1'b1, 1'b0, 1'b0); rd_chk("R6 rogue bit1", 8'h02);
    acc(1'b1, 1'b1, 2'd0, 8'hFF);
    ev(1'b0, 1'b0, 1'b1, 1'b0); rd_chk("R6 dram bit2", 8'h04);
    acc(1'b1, 1'b1, 2'd0, 8'hFF);

    // R7 and R9: every set-register data pattern
    for (int v = 0; v < 256; v++) begin
      acc(1'b1, 1'b1, 2'd0, 8'hFF);
      acc(1'b1, 1'b1, 2'd1, v[7:0]);
      rd_chk("R7 set register", v[7:0] & 8'h1C);
      chk("R9 bit7 zero", {7'd0, rdata[7]}, 8'h00);
    end

    // R2: every clear pattern against a fully populated register
    for (int p = 0; p < 256; p++) begin
      warm_rst(1'b1, 1'b0);
      ev(1'b1, 1'b1, 1'b1, 1'b0);
      acc(1'b1, 1'b1, 2'd1, 8'h18);
      acc(1'b1, 1'b1, 2'd0, p[7:0]);
      rd_chk("R2 w1c pattern", 8'h7E & ~p[7:0]);
    end

    // R1: public writes inert at every address
    warm_rst(1'b1, 1'b0);
    ev(1'b1, 1'b1, 1'b1, 1'b0);
    acc(1'b1, 1'b1, 2'd1, 8'h18);
    for (int a = 0; a < 4; a++) begin
      acc(1'b0, 1'b1, a[1:0], 8'hFF);
      rd_chk("R1 public write", 8'h7E);
      chk("R1 lock kept", {7'd0, lock}, 8'h01);
    end

    // R5: lock release and re-arm
    acc(1'b1, 1'b1, 2'd2, 8'h00);
    chk("R5 private release", {7'd0, lock}, 8'h00);
    warm_rst(1'b0, 1'b0);
    chk("R5 re-armed by bit6", {7'd0, lock}, 8'h01);
    acc(1'b1, 1'b1, 2'd2, 8'h00);
    acc(1'b1, 1'b1, 2'd0, 8'h40);
    warm_rst(1'b0, 1'b0);
    chk("R5 not armed when clear", {7'd0, lock}, 8'h00);

    // R4: reset handshake on bit6
    warm_rst(1'b1, 1'b0);
    rd_chk("R4 secrets ack sets", 8'h7E);
    warm_rst(1'b0, 1'b1);
    rd_chk("R4 clean ack clears", 8'h3E);
    chk("R4/R5 lock after clean", {7'd0, lock}, 8'h00);
    warm_rst(1'b1, 1'b1);
    rd_chk("R4 both acks set wins", 8'h7E);
    chk("R4/R5 lock after both", {7'd0, lock}, 8'h01);
    ack_c = 1'b1; step(); ack_c = 1'b0;
    rd_chk("R4 clean ack outside reset ignored", 8'h7E);
    acc(1'b1, 1'b1, 2'd0, 8'h40);
    ack_s = 1'b1; step(); ack_s = 1'b0;
    rd_chk("R4 secrets ack outside reset ignored", 8'h3E);

    // R3: warm keeps, power-on clears
    warm_rst(1'b0, 1'b0);
    rd_chk("R3 warm keeps flags", 8'h3E);
    por_pulse();
    rd_chk("R3 power-on clears", 8'h00);
    chk("R3 lock after por", {7'd0, lock}, 8'h00);

    // R8: poison
    ev(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 poison out", {7'd0, poison}, 8'h01);
    acc(1'b1, 1'b1, 2'd0, 8'hFF);
    rd_chk("R8 immune to w1c", 8'h01);
    warm_rst(1'b0, 1'b1);
    rd_chk("R8 survives warm reset", 8'h01);
    chk("R8 poison out after warm", {7'd0, poison}, 8'h01);
    por_pulse();
    chk("R8 poison cleared by por", {7'd0, poison}, 8'h00);

    // R10: event and clear in the same cycle
    ev_alias = 1'b1;
    acc(1'b1, 1'b1, 2'd0, 8'hFF);
    ev_alias = 1'b0;
    rd_chk("R10 alias beats clear", 8'h20);
    ev_dram = 1'b1;
    acc(1'b1, 1'b1, 2'd0, 8'h24);
    ev_dram = 1'b0;
    rd_chk("R10 dram beats clear", 8'h04);

    // R11: other addresses and idle cycles read zero
    for (int a = 1; a < 4; a++) begin
      acc(1'b0, 1'b0, a[1:0], 8'h00);
      chk("R11 public other addr", rdata, 8'h00);
      acc(1'b1, 1'b0, a[1:0], 8'h00);
      chk("R11 private other addr", rdata, 8'h00);
    end
    acc(1'b1, 1'b0, 2'd0, 8'h00);
    chk("R11 private status read", rdata, 8'h04);
    step();
    chk("R11 idle reads zero", rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule